// File: doc/BRIEF.md
# Prescaled Timer Counting Core

This block is the counting engine of a general-purpose timer. A 32-bit counter climbs by one whenever the functional-clock enable fires, either on every enabled tick or, with prescaling on, once per 2^(n+1) enabled ticks. When the counter rolls over it either reloads from a load register and keeps running, or stops at zero. A compare stage flags the tick on which the count lands on a programmed match value.

A control word, written by a strobe, selects the prescale, the reload behaviour, the compare and the waveform on the event pin. The pin can follow overflow alone, or overflow and match. On each selected event it either inverts or emits a one-cycle high pulse. When no source is selected, or when the counter is stopped, the pin rests at a programmable default level.

Separate strobes write the counter and the load and match registers from one shared data bus. A trigger strobe copies the load value into the counter. Register decoding and input capture are handled outside the block. All outputs are registered.

Top module: `gp_cnt_timer`

## Requirements
- R1: After reset, the counter, load, match and control values read 0. `ovf_o`, `match_o` and `pin_o` are low, and `pin_oe_o` is high.
- R2: While control bit 0 (start) is 1 and `tick_en_i` is high, the counter advances. With bit 5 (prescale enable) at 0 it advances by one on every such cycle. With bit 5 at 1 it advances once every 2^(bits 4:2 + 1) such cycles. With start at 0 the count holds.
- R3: An advance from 0xFFFFFFFF has two outcomes. With control bit 1 (reload) at 1, the counter takes the load value and keeps running. With bit 1 at 0, the counter goes to 0 and the start bit in `ctrl_o` clears.
- R4: Every wrap raises `ovf_o` for exactly one cycle, in the same cycle that `count_o` first shows the post-wrap value.
- R5: With control bit 6 (compare enable) at 1, an advance by +1 onto the match value raises `match_o` for one cycle, in the cycle that `count_o` shows that value. A wrap never raises it.
- R6: Control bits 11:10 select the pin source: 1 is overflow, 2 is overflow or match, and 0 or 3 is none. On a selected event, control bit 12 at 1 inverts the pin, and bit 12 at 0 gives a one-cycle high pulse.
- R7: When start is 0, or the source is none, the pin goes to control bit 7 (default level) one cycle later.
- R8: `pin_oe_o` is high exactly when control bit 14 is 0.
- R9: A counter write sets the count directly, and the load and match registers read back what was written. A trigger write copies the load value into the count. A counter write beats a trigger write, which beats an advance. A cycle with either write produces no advance and no event.
- R10: A control write or a counter write clears the prescale phase, so the next advance comes a full prescale period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Functional-clock tick enable |
| wdata_i | input | 32 | Shared write data |
| ctrl_we_i | input | 1 | Control write strobe (bits 14:0 used) |
| cnt_we_i | input | 1 | Counter write strobe |
| load_we_i | input | 1 | Load register write strobe |
| trig_we_i | input | 1 | Trigger strobe: count takes load value |
| match_we_i | input | 1 | Match register write strobe |
| count_o | output | 32 | Current count |
| load_o | output | 32 | Load register value |
| cmp_val_o | output | 32 | Match register value |
| ctrl_o | output | 15 | Control register value |
| ovf_o | output | 1 | Overflow event strobe |
| match_o | output | 1 | Match event strobe |
| pin_o | output | 1 | Event pin level |
| pin_oe_o | output | 1 | Event pin output enable |

## Verification
Directed runs start the counter just below 0xFFFFFFFF with reload on and with reload off. This separates reload-and-run from stop-at-zero, and toggle from pulse. Prescale runs with gated ticks and mid-period control rewrites distinguish an off-by-one period from a phase that is never cleared. A long random stream mixes control words and writes placed near the wrap and the match value with same-cycle write collisions. Its expected count, strobes and pin level come from a cycle model in the bench that is built from the requirements.

// File: rtl/gp_cnt_pkg.sv
package gp_cnt_pkg;
  localparam int PS_W = 3;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_OVF  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_RSVD = 2'd3
  } trig_e;

  // bit 14 down to bit 0
  typedef struct packed {
    logic            pin_in;
    logic            capt2;
    logic            toggle;
    trig_e           trig;
    logic [1:0]      capt;
    logic            dflt;
    logic            cmp_en;
    logic            ps_en;
    logic [PS_W-1:0] ps_val;
    logic            reload;
    logic            run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gp_cnt_prescale.sv
module gp_cnt_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            ps_en_i,
  input  logic [PS_W-1:0] ps_val_i,
  input  logic            clr_i,
  output logic            adv_o
);
  localparam int PC_W = 1 << PS_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] lim;
  logic            hit;

  assign lim   = ~({PC_W{1'b1}} << ({1'b0, ps_val_i} + (PS_W+1)'(1)));
  assign hit   = (pc_q == lim);
  assign adv_o = tick_i & run_i & (~ps_en_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (clr_i)            pc_q <= '0;
    else if (tick_i && run_i)  pc_q <= adv_o ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/gp_cnt_core.sv
module gp_cnt_core #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          reload_i,
  input  logic          cmp_en_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          cnt_we_i,
  input  logic          load_we_i,
  input  logic          trig_we_i,
  input  logic          match_we_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] match_o,
  output logic          ovf_evt_o,
  output logic          mat_evt_o,
  output logic          stop_o,
  output logic          ovf_q_o,
  output logic          mat_q_o
);
  logic [CW-1:0] cnt_q, load_q, match_q, cnt_inc;
  logic          step, wrap;

  assign cnt_inc   = cnt_q + 1'b1;
  assign wrap      = &cnt_q;
  // any write this cycle takes the counter, advance is dropped
  assign step      = adv_i & ~cnt_we_i & ~trig_we_i;
  assign ovf_evt_o = step & wrap;
  assign mat_evt_o = step & ~wrap & cmp_en_i & (cnt_inc == match_q);
  assign stop_o    = ovf_evt_o & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      ovf_q_o <= 1'b0;
      mat_q_o <= 1'b0;
    end else begin
      if (cnt_we_i)       cnt_q <= wdata_i;
      else if (trig_we_i) cnt_q <= load_q;
      else if (step)      cnt_q <= wrap ? (reload_i ? load_q : '0) : cnt_inc;
      if (load_we_i)  load_q  <= wdata_i;
      if (match_we_i) match_q <= wdata_i;
      ovf_q_o <= ovf_evt_o;
      mat_q_o <= mat_evt_o;
    end
  end

  assign cnt_o   = cnt_q;
  assign load_o  = load_q;
  assign match_o = match_q;
endmodule

// File: rtl/gp_cnt_pin.sv
module gp_cnt_pin
  import gp_cnt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  trig_e trig_i,
  input  logic  toggle_i,
  input  logic  dflt_i,
  input  logic  ovf_evt_i,
  input  logic  mat_evt_i,
  output logic  pin_o
);
  logic armed, sel, pin_d, pin_q;

  always_comb begin
    armed = run_i & ((trig_i == TRIG_OVF) | (trig_i == TRIG_BOTH));
    sel   = ovf_evt_i | ((trig_i == TRIG_BOTH) & mat_evt_i);
    if (!armed)        pin_d = dflt_i;
    else if (toggle_i) pin_d = pin_q ^ sel;
    else               pin_d = sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/gp_cnt_timer.sv
module gp_cnt_timer
  import gp_cnt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [CW-1:0]     wdata_i,
  input  logic              ctrl_we_i,
  input  logic              cnt_we_i,
  input  logic              load_we_i,
  input  logic              trig_we_i,
  input  logic              match_we_i,
  output logic [CW-1:0]     count_o,
  output logic [CW-1:0]     load_o,
  output logic [CW-1:0]     cmp_val_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ovf_o,
  output logic              match_o,
  output logic              pin_o,
  output logic              pin_oe_o
);
  ctrl_t ctrl_q;
  logic  adv, ovf_evt, mat_evt, stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q     <= '0;
    else if (ctrl_we_i) ctrl_q     <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    else if (stop)      ctrl_q.run <= 1'b0;
  end

  gp_cnt_prescale #(.PS_W(PS_W)) u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_en_i),
    .run_i    (ctrl_q.run),
    .ps_en_i  (ctrl_q.ps_en),
    .ps_val_i (ctrl_q.ps_val),
    .clr_i    (ctrl_we_i | cnt_we_i),
    .adv_o    (adv)
  );

  gp_cnt_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .reload_i   (ctrl_q.reload),
    .cmp_en_i   (ctrl_q.cmp_en),
    .wdata_i    (wdata_i),
    .cnt_we_i   (cnt_we_i),
    .load_we_i  (load_we_i),
    .trig_we_i  (trig_we_i),
    .match_we_i (match_we_i),
    .cnt_o      (count_o),
    .load_o     (load_o),
    .match_o    (cmp_val_o),
    .ovf_evt_o  (ovf_evt),
    .mat_evt_o  (mat_evt),
    .stop_o     (stop),
    .ovf_q_o    (ovf_o),
    .mat_q_o    (match_o)
  );

  gp_cnt_pin u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q.run),
    .trig_i    (ctrl_q.trig),
    .toggle_i  (ctrl_q.toggle),
    .dflt_i    (ctrl_q.dflt),
    .ovf_evt_i (ovf_evt),
    .mat_evt_i (mat_evt),
    .pin_o     (pin_o)
  );

  assign ctrl_o   = ctrl_q;
  assign pin_oe_o = ~ctrl_q.pin_in;
endmodule

// File: rtl/gp_cnt_timer_chk.sv
module gp_cnt_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_we_i,
  input logic          cnt_we_i,
  input logic          trig_we_i,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cmp_val_o,
  input logic [14:0]   ctrl_o,
  input logic          ovf_o,
  input logic          match_o,
  input logic          pin_o
);
  assert_stopped_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!ctrl_o[0]) && $past(!cnt_we_i) && $past(!trig_we_i)) |-> $stable(count_o));

  assert_wrap_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ctrl_o[1] && $past(!ctrl_we_i)) |-> (count_o == '0 && !ctrl_o[0]));

  assert_ovf_from_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(count_o) == {CW{1'b1}}));

  assert_match_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (count_o == $past(cmp_val_o)));

  assert_pulse_only_on_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_o[0]) && ($past(ctrl_o[11:10]) == 2'd1) && $past(!ctrl_o[12]) && !ovf_o)
      |-> !pin_o);

  assert_default_when_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_o[0]) |-> (pin_o == $past(ctrl_o[7])));
endmodule

bind gp_cnt_timer gp_cnt_timer_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we_i (ctrl_we_i),
  .cnt_we_i  (cnt_we_i),
  .trig_we_i (trig_we_i),
  .count_o   (count_o),
  .cmp_val_o (cmp_val_o),
  .ctrl_o    (ctrl_o),
  .ovf_o     (ovf_o),
  .match_o   (match_o),
  .pin_o     (pin_o)
);

// File: tb/gp_cnt_timer_tb_top.sv
module gp_cnt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        ctrl_we_i = 1'b0, cnt_we_i = 1'b0, load_we_i = 1'b0;
  logic        trig_we_i = 1'b0, match_we_i = 1'b0;
  logic [31:0] count_o, load_o, cmp_val_o;
  logic [14:0] ctrl_o;
  logic        ovf_o, match_o, pin_o, pin_oe_o;

  always #4 clk = ~clk;

  gp_cnt_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .wdata_i(wdata_i),
    .ctrl_we_i(ctrl_we_i), .cnt_we_i(cnt_we_i), .load_we_i(load_we_i),
    .trig_we_i(trig_we_i), .match_we_i(match_we_i),
    .count_o(count_o), .load_o(load_o), .cmp_val_o(cmp_val_o), .ctrl_o(ctrl_o),
    .ovf_o(ovf_o), .match_o(match_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_cnt = '0, m_load = '0, m_cmp = '0;
  logic [14:0] m_ctrl = '0;
  logic [7:0]  m_pc = '0;
  logic        m_pin = 0, m_ovf = 0, m_mat = 0;

  function automatic logic [7:0] ps_lim(input logic [2:0] v);
    return ~(8'hFF << ({1'b0, v} + 4'd1));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check("R2 R3 R9 count_o", count_o, m_cnt);
    check("R9 load_o", load_o, m_load);
    check("R9 cmp_val_o", cmp_val_o, m_cmp);
    check("R3 ctrl_o", {17'd0, ctrl_o}, {17'd0, m_ctrl});
    check("R4 ovf_o", {31'd0, ovf_o}, {31'd0, m_ovf});
    check("R5 match_o", {31'd0, match_o}, {31'd0, m_mat});
    check("R6 R7 pin_o", {31'd0, pin_o}, {31'd0, m_pin});
    check("R8 pin_oe_o", {31'd0, pin_oe_o}, {31'd0, ~m_ctrl[14]});
  endtask

  task automatic cyc(input bit cw, input bit nw, input bit lw, input bit tw,
                     input bit mw, input logic [31:0] d, input bit tk);
    logic run, adv, step, wrap, ovf, mat, armed, sel, npin;
    logic [1:0] trg;
    ctrl_we_i = cw; cnt_we_i = nw; load_we_i = lw; trig_we_i = tw;
    match_we_i = mw; wdata_i = d; tick_en_i = tk;
    run   = m_ctrl[0];
    adv   = tk && run && (!m_ctrl[5] || m_pc == ps_lim(m_ctrl[4:2]));
    step  = adv && !nw && !tw;
    wrap  = (m_cnt == 32'hFFFF_FFFF);
    ovf   = step && wrap;
    mat   = step && !wrap && m_ctrl[6] && ((m_cnt + 32'd1) == m_cmp);
    trg   = m_ctrl[11:10];
    armed = run && (trg == 2'd1 || trg == 2'd2);
    sel   = ovf || (trg == 2'd2 && mat);
    npin  = !armed ? m_ctrl[7] : (m_ctrl[12] ? (m_pin ^ sel) : sel);
    if (cw || nw)       m_pc = '0;
    else if (tk && run) m_pc = adv ? 8'd0 : m_pc + 8'd1;
    if (nw)        m_cnt = d;
    else if (tw)   m_cnt = m_load;
    else if (step) m_cnt = wrap ? (m_ctrl[1] ? m_load : 32'd0) : m_cnt + 32'd1;
    if (cw)                     m_ctrl = d[14:0];
    else if (ovf && !m_ctrl[1]) m_ctrl[0] = 1'b0;
    if (lw) m_load = d;
    if (mw) m_cmp = d;
    m_pin = npin; m_ovf = ovf; m_mat = mat;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle(input int n, input bit tk = 1);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 32'd0, tk);
  endtask

  task automatic wr_ctrl(input logic [31:0] d);  cyc(1, 0, 0, 0, 0, d, 1); endtask
  task automatic wr_cnt(input logic [31:0] d);   cyc(0, 1, 0, 0, 0, d, 1); endtask
  task automatic wr_load(input logic [31:0] d);  cyc(0, 0, 1, 0, 0, d, 1); endtask
  task automatic wr_match(input logic [31:0] d); cyc(0, 0, 0, 0, 1, d, 1); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    cmp_all();
    check("R1 pin_oe_o after reset", {31'd0, pin_oe_o}, 32'd1);
    check("R1 count_o after reset", count_o, 32'd0);

    // R9: load and match readback
    wr_load(32'h0000_0100);
    wr_match(32'h0000_0005);
    // R2: plain counting, then gated ticks
    wr_cnt(32'd0);
    wr_ctrl(32'h0000_0001);
    idle(8);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, 32'd0, i[0]);
    // R2 R10: prescale of 4, rewrite mid-period
    wr_ctrl(32'h0000_0025);
    idle(14);
    wr_ctrl(32'h0000_0025);
    idle(2);
    wr_cnt(32'd50);
    idle(10);
    // R5 R6: compare with pulse on overflow or match
    wr_cnt(32'd0);
    wr_ctrl(32'h0000_0841);
    idle(8);
    // R3 R6: reload wrap with toggle on overflow
    wr_cnt(32'hFFFF_FFFD);
    wr_ctrl(32'h0000_1403);
    idle(8);
    wr_cnt(32'hFFFF_FFFE);
    idle(6);
    // R3 R7: wrap without reload stops, default level high
    wr_cnt(32'hFFFF_FFFE);
    wr_ctrl(32'h0000_0881);
    idle(6);
    // R7: reserved source acts as none
    wr_ctrl(32'h0000_0C81);
    idle(4);
    wr_ctrl(32'h0000_0000);
    idle(2);
    // R8: pin direction input
    wr_ctrl(32'h0000_4000);
    idle(2);
    wr_ctrl(32'h0000_0001);
    // R9: trigger copies load; counter write beats trigger
    wr_load(32'h0000_0ABC);
    cyc(0, 0, 0, 1, 0, 32'd0, 1);
    idle(2);
    cyc(0, 1, 0, 1, 0, 32'h77, 1);
    idle(2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] d;
      bit cw, nw, lw, tw, mw, tk;
      r  = $urandom_range(0, 99);
      cw = 0; nw = 0; lw = 0; tw = 0; mw = 0;
      d  = $urandom;
      tk = ($urandom_range(0, 9) < 8);
      if (r < 3) begin
        cw = 1;
        d[0] = ($urandom_range(0, 9) < 7);
        if ($urandom_range(0, 3) != 0) d[4:2] = 3'($urandom_range(0, 1));
      end else if (r < 6) begin
        nw = 1; d = 32'hFFFF_FFFF - $urandom_range(0, 60);
      end else if (r < 8) begin
        lw = 1;
        if ($urandom_range(0, 1) == 1) d = 32'hFFFF_FFFF - $urandom_range(0, 40);
      end else if (r < 10) begin
        mw = 1; d = m_cnt + $urandom_range(0, 30);
      end else if (r < 11) begin
        tw = 1;
      end
      if ($urandom_range(0, 49) == 0) nw = 1;
      cyc(cw, nw, lw, tw, mw, d, tk);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule